// File: doc/BRIEF.md
# Predicated SIMD Lane Arithmetic Unit

This block is a vector integer execution stage. It treats each 512-bit operand as sixteen 32-bit lanes and applies one operation to all lanes at once. A 16-bit predicate selects which lanes take part. The available operations are wrapping add, wrapping subtract, equality compare and tail-mask generation. A lane that the predicate switches off does not get the arithmetic result. Instead it passes through its old destination value, or it is cleared to zero, depending on a per-request flag. A compare does not write vector lanes. It returns one bit per lane as a packed mask. The tail-mask operation converts a count of remaining elements into a mask whose low bits are set, so the last partial vector of a loop can be handled under predication.

A request enters on a valid/ready stream and its result leaves on a second valid/ready stream. A single output register sits between the two, so latency is one cycle. The input is accepted only when that register is empty or is being drained in the same cycle. While a result waits with `out_ready` low, the result is held unchanged and no new request is taken.

Top module: `simd_pred_alu`

## Requirements
- R1: With `in_op` = 2'b00 (add), each active lane n (bits [32n+31:32n], predicate bit n = 1) outputs (A_n + B_n) mod 2^32, and `out_mask` is all zeros.
- R2: With `in_op` = 2'b01 (subtract), each active lane outputs (A_n − B_n) mod 2^32, and `out_mask` is all zeros.
- R3: For add or subtract with `in_zero` = 0, each inactive lane outputs the lane's value from `in_dst_old` unchanged.
- R4: For add or subtract with `in_zero` = 1, each inactive lane outputs 0.
- R5: With `in_op` = 2'b10 (compare-equal), `out_mask` bit n is 1 exactly when predicate bit n is 1 and A_n equals B_n. `out_vec` is all zeros.
- R6: With `in_op` = 2'b11 (tail mask), `out_mask` has its low min(`in_count`,16) bits set and all other bits clear. `in_mask`, `in_zero` and the source vectors have no effect. `out_vec` is all zeros.
- R7: With an all-ones predicate, add and subtract give the full-width result in every lane, whatever the value of `in_zero`.
- R8: A request accepted on a rising edge (`in_valid` and `in_ready` both 1) is presented on `out_valid`/`out_vec`/`out_mask` after that edge. `out_valid` is 0 when no result is pending.
- R9: Back-pressure: `in_ready` is 1 exactly when no result is pending or `out_ready` is 1. While `out_valid` = 1 and `out_ready` = 0, the outputs stay constant.
- R10: During and right after reset (`rst_n` = 0, active low), `out_valid` is 0, `out_vec` and `out_mask` are zero, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 2 | 00 add, 01 subtract, 10 compare-equal, 11 tail mask |
| in_zero | input | 1 | 1: inactive lanes cleared; 0: inactive lanes keep old value |
| in_mask | input | 16 | Per-lane predicate, bit n for lane n |
| in_count | input | 5 | Remaining-element count for the tail-mask operation |
| in_src_a | input | 512 | Source vector A |
| in_src_b | input | 512 | Source vector B |
| in_dst_old | input | 512 | Previous destination vector, used for merge |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 512 | Lane result vector |
| out_mask | output | 16 | Compare or tail mask result |

## Verification
The bench targets lane sums that overflow and differences that borrow. A design that leaked a carry across lanes, or that saturated, would corrupt the neighbouring lane or pin the value at its limit. The bench also mixes merge and zero requests under sparse, empty and full predicates. A design that swapped the two inactive-lane policies, or that ignored the predicate on compare, would give wrong values in specific lanes. Tail counts of 0, 15, 16 and above 16 are included, where an off-by-one, or a shift that wraps past 16, would give a wrong mask. Random stalls on `out_ready` show whether the design drops a result, duplicates one, or changes it while it waits.

// File: rtl/simd_pred_pkg.sv
package simd_pred_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_CMPEQ = 2'b10,
    OP_TAIL  = 2'b11
  } simd_op_e;

  function automatic logic op_writes_lanes(simd_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_pred_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  simd_op_e          op,
  input  logic              active,
  input  logic              zero_inactive,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] old,
  output logic [LANE_W-1:0] res,
  output logic              hit
);

  logic [LANE_W-1:0] arith;
  logic [LANE_W-1:0] idle_val;

  always_comb begin
    arith = (op == OP_SUB) ? (a - b) : (a + b);
  end

  assign idle_val = zero_inactive ? '0 : old;

  always_comb begin
    res = '0;
    hit = 1'b0;
    if (op_writes_lanes(op)) begin
      res = active ? arith : idle_val;
    end else if (op == OP_CMPEQ) begin
      hit = active && (a == b);
    end
  end

endmodule

// File: rtl/simd_tail_gen.sv
module simd_tail_gen #(
  parameter  int LANES = 16,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic [LANES-1:0] mask
);

  for (genvar i = 0; i < LANES; i++) begin : g_bit
    assign mask[i] = (count > CNT_W'(i));
  end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  d_vec,
  input  logic [MASK_W-1:0] d_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_vec,
  output logic [MASK_W-1:0] out_mask
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_mask  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_vec   <= d_vec;
      out_mask  <= d_mask;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_pred_alu.sv
module simd_pred_alu
  import simd_pred_pkg::*;
#(
  parameter  int LANES  = 16,
  parameter  int LANE_W = 32,
  localparam int VEC_W  = LANES * LANE_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic             in_zero,
  input  logic [LANES-1:0] in_mask,
  input  logic [CNT_W-1:0] in_count,
  input  logic [VEC_W-1:0] in_src_a,
  input  logic [VEC_W-1:0] in_src_b,
  input  logic [VEC_W-1:0] in_dst_old,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec,
  output logic [LANES-1:0] out_mask
);

  simd_op_e         op;
  logic [VEC_W-1:0] lane_res;
  logic [LANES-1:0] cmp_hits;
  logic [LANES-1:0] tail_bits;
  logic [LANES-1:0] next_mask;

  assign op = simd_op_e'(in_op);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    simd_lane_op #(
      .LANE_W(LANE_W)
    ) u_lane (
      .op           (op),
      .active       (in_mask[n]),
      .zero_inactive(in_zero),
      .a            (in_src_a[n*LANE_W +: LANE_W]),
      .b            (in_src_b[n*LANE_W +: LANE_W]),
      .old          (in_dst_old[n*LANE_W +: LANE_W]),
      .res          (lane_res[n*LANE_W +: LANE_W]),
      .hit          (cmp_hits[n])
    );
  end

  simd_tail_gen #(
    .LANES(LANES)
  ) u_tail (
    .count(in_count),
    .mask (tail_bits)
  );

  always_comb begin
    case (op)
      OP_CMPEQ: next_mask = cmp_hits;
      OP_TAIL:  next_mask = tail_bits;
      default:  next_mask = '0;
    endcase
  end

  simd_out_stage #(
    .VEC_W (VEC_W),
    .MASK_W(LANES)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d_vec    (lane_res),
    .d_mask   (next_mask),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_vec  (out_vec),
    .out_mask (out_mask)
  );

endmodule

// File: rtl/simd_pred_alu_chk.sv
module simd_pred_alu_chk #(
  parameter  int LANES  = 16,
  parameter  int LANE_W = 32,
  localparam int VEC_W  = LANES * LANE_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_op,
  input logic             in_zero,
  input logic [LANES-1:0] in_mask,
  input logic [CNT_W-1:0] in_count,
  input logic [VEC_W-1:0] in_dst_old,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic [LANES-1:0] out_mask
);

  logic fire;
  assign fire = in_valid && in_ready;

  // R8: accepted request shows up one edge later
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R9: stalled result is held
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_mask)));

  // R9: no acceptance while a stalled result occupies the stage
  a_r9_no_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R1 and R2: lane-writing operations return an empty mask
  a_r1_vec_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_op[1]) |=> (out_mask == '0));

  // R3: lane 0 inactive in merge mode keeps its old value
  a_r3_merge_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_op[1] && !in_zero && !in_mask[0])
      |=> (out_vec[LANE_W-1:0] == $past(in_dst_old[LANE_W-1:0])));

  // R4: empty predicate in zero mode clears every lane
  a_r4_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_op[1] && in_zero && (in_mask == '0)) |=> (out_vec == '0));

  // R5: compare never flags an inactive lane
  a_r5_cmp_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == 2'b10)) |=> ((out_mask & ~$past(in_mask)) == '0));

  // R6: lowest tail bit set exactly for a nonzero count
  a_r6_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == 2'b11)) |=> (out_mask[0] == ($past(in_count) != '0)));

endmodule

bind simd_pred_alu simd_pred_alu_chk #(
  .LANES (LANES),
  .LANE_W(LANE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_zero   (in_zero),
  .in_mask   (in_mask),
  .in_count  (in_count),
  .in_dst_old(in_dst_old),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec),
  .out_mask  (out_mask)
);

// File: tb/simd_pred_alu_bench.sv
module simd_pred_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 16;
  localparam int LANE_W     = 32;
  localparam int VEC_W      = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_op = 2'b00;
  logic             in_zero = 1'b0;
  logic [LANES-1:0] in_mask = '0;
  logic [4:0]       in_count = '0;
  logic [VEC_W-1:0] in_src_a = '0;
  logic [VEC_W-1:0] in_src_b = '0;
  logic [VEC_W-1:0] in_dst_old = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VEC_W-1:0] out_vec;
  logic [LANES-1:0] out_mask;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit stall_en = 1'b0;

  logic [VEC_W-1:0] qv[$];
  logic [LANES-1:0] qm[$];
  string            qt[$];

  simd_pred_alu u_simd_pred_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_zero(in_zero), .in_mask(in_mask), .in_count(in_count),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst_old(in_dst_old),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec), .out_mask(out_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [VEC_W-1:0] mkvec(int unsigned seed);
    logic [VEC_W-1:0] v;
    for (int n = 0; n < LANES; n++) begin
      logic [31:0] x;
      x = seed * 32'h9E3779B9 + 32'(n) * 32'h01000193;
      v[n*32 +: 32] = x ^ (x >> 13);
    end
    return v;
  endfunction

  // behavioural reference: expected vector, mask and requirement tag
  task automatic model_push();
    logic [VEC_W-1:0] v;
    logic [LANES-1:0] m;
    string tag;
    string base;
    v = '0;
    m = '0;
    if (in_op == 2'b11) begin
      m = (in_count >= 5'd16) ? 16'hFFFF : 16'((32'd1 << in_count) - 32'd1);
      tag = "R6";
    end else if (in_op == 2'b10) begin
      for (int n = 0; n < LANES; n++)
        m[n] = in_mask[n] && (in_src_a[n*32 +: 32] == in_src_b[n*32 +: 32]);
      tag = "R5";
    end else begin
      for (int n = 0; n < LANES; n++) begin
        logic [31:0] a;
        logic [31:0] b;
        a = in_src_a[n*32 +: 32];
        b = in_src_b[n*32 +: 32];
        if (in_mask[n]) v[n*32 +: 32] = (in_op == 2'b01) ? a - b : a + b;
        else if (in_zero) v[n*32 +: 32] = 32'd0;
        else v[n*32 +: 32] = in_dst_old[n*32 +: 32];
      end
      base = (in_op == 2'b01) ? "R2" : "R1";
      if (in_mask == 16'hFFFF) tag = {base, "/R7"};
      else if (in_zero) tag = {base, "/R4"};
      else tag = {base, "/R3"};
    end
    qv.push_back(v);
    qm.push_back(m);
    qt.push_back({tag, "/R8"});
  endtask

  task automatic check1(bit ok, string tag, logic [VEC_W-1:0] got_v, logic [VEC_W-1:0] exp_v,
                        logic [LANES-1:0] got_m, logic [LANES-1:0] exp_m);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got vec=%h mask=%h exp vec=%h mask=%h", tag, got_v, got_m, exp_v, exp_m);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    #1;
    out_ready = stall_en ? ((cyc % 7) != 2 && (cyc % 7) != 3 && (cyc % 5) != 4) : 1'b1;
  end

  // per-cycle comparison against the reference queue, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (qv.size() == 0) begin
          check1(1'b0, "R8 unexpected result", out_vec, '0, out_mask, '0);
        end else begin
          check1((out_vec == qv[0]) && (out_mask == qm[0]), qt[0], out_vec, qv[0], out_mask, qm[0]);
          if (out_ready) begin
            void'(qv.pop_front());
            void'(qm.pop_front());
            void'(qt.pop_front());
          end
        end
      end else if (qv.size() != 0) begin
        check1(1'b0, "R8 missing result", out_vec, qv[0], out_mask, qm[0]);
      end
      checks++;
      if (in_ready != (!out_valid || out_ready)) begin
        failures++;
        $display("FAIL R9 in_ready got %0b exp %0b", in_ready, (!out_valid || out_ready));
      end
      if (in_valid && in_ready) model_push();
    end
  end

  task automatic send(logic [1:0] op, logic zero, logic [LANES-1:0] mask, logic [4:0] cnt,
                      logic [VEC_W-1:0] a, logic [VEC_W-1:0] b, logic [VEC_W-1:0] old);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_op = op;
    in_zero = zero;
    in_mask = mask;
    in_count = cnt;
    in_src_a = a;
    in_src_b = b;
    in_dst_old = old;
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic go_idle();
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] va;
    logic [VEC_W-1:0] vb;
    logic [VEC_W-1:0] vo;
    logic [VEC_W-1:0] ones;
    logic [VEC_W-1:0] lane_one;
    ones = '1;
    for (int n = 0; n < LANES; n++) lane_one[n*32 +: 32] = 32'd1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check1(!out_valid && out_vec == '0 && out_mask == '0 && in_ready, "R10 reset state",
           out_vec, '0, out_mask, '0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check1(!out_valid && out_vec == '0 && out_mask == '0 && in_ready, "R10 after reset",
           out_vec, '0, out_mask, '0);

    va = mkvec(1); vb = mkvec(2); vo = mkvec(3);
    send(2'b00, 1'b0, 16'hF0F0, 5'd0, va, vb, vo);      // R1/R3
    send(2'b00, 1'b1, 16'h0F0F, 5'd0, va, vb, vo);      // R1/R4
    send(2'b00, 1'b0, 16'hFFFF, 5'd0, ones, lane_one, vo); // R1/R7 wrap
    send(2'b01, 1'b1, 16'hFFFF, 5'd0, '0, lane_one, vo);   // R2/R7 borrow
    send(2'b01, 1'b0, 16'h8001, 5'd0, va, vb, vo);      // R2/R3
    send(2'b01, 1'b1, 16'h0000, 5'd0, va, vb, vo);      // R2/R4 empty
    send(2'b00, 1'b0, 16'h0000, 5'd0, va, vb, vo);      // R1/R3 empty
    vb = va;
    vb[3*32 +: 32] = ~vb[3*32 +: 32];
    vb[8*32 +: 32] = vb[8*32 +: 32] + 32'd1;
    send(2'b10, 1'b0, 16'hFF7F, 5'd0, va, vb, vo);      // R5 partial
    send(2'b10, 1'b1, 16'hFFFF, 5'd0, va, va, vo);      // R5 full
    send(2'b10, 1'b0, 16'h0000, 5'd0, va, va, vo);      // R5 empty predicate
    foreach (qv[i]) ;
    // R6: tail counts incl. 0, 16 and beyond
    send(2'b11, 1'b1, 16'h1234, 5'd0, va, vb, vo);
    send(2'b11, 1'b0, 16'h0000, 5'd1, va, vb, vo);
    send(2'b11, 1'b1, 16'hFFFF, 5'd5, va, vb, vo);
    send(2'b11, 1'b0, 16'hAAAA, 5'd15, va, vb, vo);
    send(2'b11, 1'b0, 16'h5555, 5'd16, va, vb, vo);
    send(2'b11, 1'b1, 16'h0001, 5'd17, va, vb, vo);
    send(2'b11, 1'b0, 16'h0000, 5'd31, va, vb, vo);
    go_idle();
    repeat (3) @(posedge clk);

    // R9: mixed traffic under back-pressure
    stall_en = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [VEC_W-1:0] sa;
      logic [VEC_W-1:0] sb;
      sa = mkvec(k + 10);
      sb = (k % 3 == 0) ? sa : mkvec(k + 90);
      if (k % 4 == 1) sb[5*32 +: 32] = sa[5*32 +: 32];
      send(2'(k % 4), 1'(k % 2), 16'(mkvec(k + 40)), 5'(k % 20), sa, sb, mkvec(k + 70));
      if (k % 9 == 4) begin
        go_idle();
        @(posedge clk);
      end
    end
    go_idle();
    stall_en = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    checks++;
    if (qv.size() != 0 || out_valid) begin
      failures++;
      $display("FAIL R8 drain got pending=%0d exp 0", qv.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule